// File: doc/BRIEF.md
# Cell-Granular Dual-Clock FIFO with Cell Discard

This block moves fixed-size cells of 8-bit words from one clock domain to a second, fully asynchronous clock domain. The producer writes the words of a cell one at a time. It then either commits the cell, which hands it to the consumer, or discards it. A discard rewinds the write pointer to the first word of the cell, so none of the cell's words is ever seen on the read side. The cell length is a static configuration input, an even number of words from 16 to 128. It is wired at board level or held constant between resets.

The backing store holds 2048 words. A new cell is admitted only if the words already committed and unread, plus one more cell, still fit in 1536 words. If not, the whole cell is refused and a one-cycle refusal flag is raised. Only whole committed cells count as available to the consumer. A cell becomes visible as soon as its commit has crossed into the read domain, with no further hold-off.

The read side shows the current word and its start-of-cell marker whenever a full cell is available. A read enable pops one word. The consumer can therefore hold a word for as long as it likes, or drain cells back to back at one word per cycle.

Top module: `cellq_fifo`

## Requirements
- R1: After reset is released, rdCellAvail, rdSoc and wrReject are all low, and no cell is available until one has been committed.
- R2: Every committed cell is delivered intact and in commit order. rdCellAvail stays high until the last word of every available cell has been popped.
- R3: rdSoc is high on the first word of each delivered cell and low on every other word.
- R4: A wrDrop strobe (wrDrop has priority over wrCommit) discards the open cell. None of its words is delivered, and the next committed cell is read out correctly.
- R5: A wrCommit issued when the open cell holds fewer than cellSize words acts as a discard, and the cell is not delivered.
- R6: Write beats that arrive after a cell already holds cellSize words are ignored. A later commit delivers exactly the first cellSize words.
- R7: A wrValid beat with wrSoc high, arriving while a cell is open and uncommitted, abandons the open cell and starts a new one.
- R8: A start-of-cell beat is admitted only if committed unread words plus cellSize do not exceed 1536. Otherwise the cell is not stored, and wrReject is high for the one write-clock cycle after that beat. With nothing unread, exactly floor(1536/cellSize) cells fit.
- R9: A read enable given while rdCellAvail is low has no effect on what is read later.
- R10: A cell whose words are all written but not yet committed is never reported available. A commit issued later, in a cycle of its own, delivers that cell.
- R11: Cell boundaries follow the cellSize input. With cellSize 128, each delivered cell is 128 words long with rdSoc on its first word.
- R12: While rdCellAvail is high and rdEn is low, rdData and rdSoc hold their values (show-ahead read port).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Active-high asynchronous reset for both domains |
| cellSize | input | 8 | Static cell length in words (16 to 128, even) |
| wrClk | input | 1 | Write-domain clock |
| wrValid | input | 1 | Write beat valid |
| wrSoc | input | 1 | Beat is the first word of a cell |
| wrData | input | 8 | Write word |
| wrCommit | input | 1 | Commit the open cell (write beat ignored in this cycle) |
| wrDrop | input | 1 | Discard the open cell (write beat ignored in this cycle) |
| wrReject | output | 1 | One-cycle pulse: the last start-of-cell was refused for lack of space |
| rdClk | input | 1 | Read-domain clock |
| rdEn | input | 1 | Pop the current word |
| rdCellAvail | output | 1 | At least one whole committed cell is unread |
| rdSoc | output | 1 | Current word is the first of a cell |
| rdData | output | 8 | Current word |

## Verification
Directed sequences each isolate one ending of a cell: a delayed commit, a drop after a partial cell and after a full cell, a short commit, an over-long cell, and a new start of cell landing on an open cell. Each one is followed by a good cell, so that a pointer rewound to the wrong place shows up as misaligned data or a misplaced start-of-cell marker. A fill run with no reads separates the exact admission limit from an off-by-one-cell bound. Constrained-random runs at cell lengths 16 and 128 mix good, dropped, short and long cells while the reader drains at full speed, which exposes ordering and cell-boundary errors in the cell count carried across domains.

// File: rtl/cellq_pkg.sv
package cellq_pkg;
  parameter int ADDR_W    = 11;   // 2048-word backing store
  parameter int WORD_W    = 8;
  parameter int SIZE_W    = 8;    // width of the cell length input
  parameter int CNT_W     = 8;    // committed-cell counter width
  parameter int CAP_WORDS = 1536; // admission limit in words

  localparam int PTR_W  = ADDR_W + 1;
  localparam int NEED_W = PTR_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [ADDR_W-1:0] rdAddr;
  } memCtlT;
endpackage

// File: rtl/cellq_gsync.sv
module cellq_gsync #(
  parameter int W = 8
) (
  input  logic         srcClk,
  input  logic         dstClk,
  input  logic         rst,
  input  logic [W-1:0] binIn,
  output logic [W-1:0] binOut
);
  logic [W-1:0] grayQ;
  logic [W-1:0] meta;
  logic [W-1:0] sync;

  always_ff @(posedge srcClk or posedge rst) begin
    if (rst) grayQ <= '0;
    else     grayQ <= binIn ^ (binIn >> 1);
  end

  always_ff @(posedge dstClk or posedge rst) begin
    if (rst) begin
      meta <= '0;
      sync <= '0;
    end else begin
      meta <= grayQ;
      sync <= meta;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_g2b
    assign binOut[i] = ^sync[W-1:i];
  end
endmodule

// File: rtl/cellq_ctrl.sv
module cellq_ctrl
  import cellq_pkg::*;
(
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rst,
  input  logic [SIZE_W-1:0] cellSize,
  input  logic              wrValid,
  input  logic              wrSoc,
  input  logic              wrCommit,
  input  logic              wrDrop,
  output logic              wrReject,
  input  logic              rdEn,
  output logic              rdCellAvail,
  output logic              rdSoc,
  output memCtlT            memCtl
);
  // ---------------- write domain ----------------
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  commitPtr;
  logic [PTR_W-1:0]  rdPtrW;
  logic [CNT_W-1:0]  commitCnt;
  logic [SIZE_W-1:0] wordCnt;
  logic              inCell;
  logic              rejectQ;

  logic [PTR_W-1:0]  occWords;
  logic [NEED_W-1:0] needWords;
  logic              admit;
  logic              cellFull;
  logic              endStrobe;
  logic              commitOk;

  always_comb begin
    occWords  = commitPtr - rdPtrW;
    needWords = {1'b0, occWords} + NEED_W'(cellSize);
    admit     = needWords <= NEED_W'(CAP_WORDS);
    cellFull  = wordCnt == cellSize;
    endStrobe = wrCommit || wrDrop;
    commitOk  = wrCommit && !wrDrop && inCell && cellFull;
  end

  always_ff @(posedge wrClk or posedge rst) begin
    if (rst) begin
      wrPtr     <= '0;
      commitPtr <= '0;
      commitCnt <= '0;
      wordCnt   <= '0;
      inCell    <= 1'b0;
      rejectQ   <= 1'b0;
    end else begin
      rejectQ <= 1'b0;
      if (commitOk) begin
        commitPtr <= wrPtr;
        commitCnt <= commitCnt + CNT_W'(1);
        inCell    <= 1'b0;
      end else if (endStrobe) begin
        wrPtr  <= commitPtr;
        inCell <= 1'b0;
      end else if (wrValid && wrSoc) begin
        if (admit) begin
          wrPtr   <= commitPtr + PTR_W'(1);
          wordCnt <= SIZE_W'(1);
          inCell  <= 1'b1;
        end else begin
          wrPtr   <= commitPtr;
          inCell  <= 1'b0;
          rejectQ <= 1'b1;
        end
      end else if (wrValid && inCell && !cellFull) begin
        wrPtr   <= wrPtr + PTR_W'(1);
        wordCnt <= wordCnt + SIZE_W'(1);
      end
    end
  end

  assign wrReject = rejectQ;

  always_comb begin
    memCtl.wrEn   = wrValid && !endStrobe && (wrSoc ? admit : (inCell && !cellFull));
    memCtl.wrAddr = wrSoc ? commitPtr[ADDR_W-1:0] : wrPtr[ADDR_W-1:0];
  end

  // ---------------- read domain ----------------
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  rdCellCnt;
  logic [CNT_W-1:0]  commitCntR;
  logic [SIZE_W-1:0] rdIdx;
  logic              pop;
  logic              lastWord;

  always_comb begin
    rdCellAvail   = commitCntR != rdCellCnt;
    pop           = rdEn && rdCellAvail;
    lastWord      = rdIdx == (cellSize - SIZE_W'(1));
    rdSoc         = rdCellAvail && (rdIdx == '0);
    memCtl.rdAddr = rdPtr[ADDR_W-1:0];
  end

  always_ff @(posedge rdClk or posedge rst) begin
    if (rst) begin
      rdPtr     <= '0;
      rdCellCnt <= '0;
      rdIdx     <= '0;
    end else if (pop) begin
      rdPtr <= rdPtr + PTR_W'(1);
      if (lastWord) begin
        rdIdx     <= '0;
        rdCellCnt <= rdCellCnt + CNT_W'(1);
      end else begin
        rdIdx <= rdIdx + SIZE_W'(1);
      end
    end
  end

  // ---------------- crossings ----------------
  cellq_gsync #(.W(CNT_W)) cntSync_i (
    .srcClk (wrClk),
    .dstClk (rdClk),
    .rst    (rst),
    .binIn  (commitCnt),
    .binOut (commitCntR)
  );

  cellq_gsync #(.W(PTR_W)) ptrSync_i (
    .srcClk (rdClk),
    .dstClk (wrClk),
    .rst    (rst),
    .binIn  (rdPtr),
    .binOut (rdPtrW)
  );
endmodule

// File: rtl/cellq_dpath.sv
module cellq_dpath
  import cellq_pkg::*;
(
  input  logic              wrClk,
  input  memCtlT            memCtl,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData
);
  logic [WORD_W-1:0] store [DEPTH];

  always_ff @(posedge wrClk) begin
    if (memCtl.wrEn) store[memCtl.wrAddr] <= wrData;
  end

  assign rdData = store[memCtl.rdAddr];
endmodule

// File: rtl/cellq_fifo.sv
module cellq_fifo
  import cellq_pkg::*;
(
  input  logic              rst,
  input  logic [SIZE_W-1:0] cellSize,
  input  logic              wrClk,
  input  logic              wrValid,
  input  logic              wrSoc,
  input  logic [WORD_W-1:0] wrData,
  input  logic              wrCommit,
  input  logic              wrDrop,
  output logic              wrReject,
  input  logic              rdClk,
  input  logic              rdEn,
  output logic              rdCellAvail,
  output logic              rdSoc,
  output logic [WORD_W-1:0] rdData
);
  memCtlT memCtl;

  cellq_ctrl ctrl_i (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rst         (rst),
    .cellSize    (cellSize),
    .wrValid     (wrValid),
    .wrSoc       (wrSoc),
    .wrCommit    (wrCommit),
    .wrDrop      (wrDrop),
    .wrReject    (wrReject),
    .rdEn        (rdEn),
    .rdCellAvail (rdCellAvail),
    .rdSoc       (rdSoc),
    .memCtl      (memCtl)
  );

  cellq_dpath dpath_i (
    .wrClk  (wrClk),
    .memCtl (memCtl),
    .wrData (wrData),
    .rdData (rdData)
  );
endmodule

// File: rtl/cellq_fifo_chk.sv
module cellq_fifo_chk
  import cellq_pkg::*;
(
  input logic              rst,
  input logic              wrClk,
  input logic              wrValid,
  input logic              wrSoc,
  input logic              wrCommit,
  input logic              wrDrop,
  input logic              wrReject,
  input logic              rdClk,
  input logic              rdEn,
  input logic              rdCellAvail,
  input logic              rdSoc,
  input logic [WORD_W-1:0] rdData
);
  AST_AVAIL_HELD: assert property (@(posedge rdClk) disable iff (rst)
    (rdCellAvail && !rdEn) |=> rdCellAvail); // R2

  AST_SOC_SINGLE: assert property (@(posedge rdClk) disable iff (rst)
    (rdCellAvail && rdEn && rdSoc) |=> !rdSoc); // R3

  AST_REJECT_CAUSE: assert property (@(posedge wrClk) disable iff (rst)
    wrReject |-> $past(wrValid && wrSoc && !wrCommit && !wrDrop)); // R8

  AST_WORD_HELD: assert property (@(posedge rdClk) disable iff (rst)
    (rdCellAvail && !rdEn) |=> ($stable(rdData) && $stable(rdSoc))); // R12
endmodule

bind cellq_fifo cellq_fifo_chk chk_i (
  .rst         (rst),
  .wrClk       (wrClk),
  .wrValid     (wrValid),
  .wrSoc       (wrSoc),
  .wrCommit    (wrCommit),
  .wrDrop      (wrDrop),
  .wrReject    (wrReject),
  .rdClk       (rdClk),
  .rdEn        (rdEn),
  .rdCellAvail (rdCellAvail),
  .rdSoc       (rdSoc),
  .rdData      (rdData)
);

// File: tb/cellq_fifo_tb_top.sv
module cellq_fifo_tb_top;
  logic       wrClk = 1'b0;
  logic       rdClk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cellSize = 8'd16;
  logic       wrValid = 1'b0, wrSoc = 1'b0, wrCommit = 1'b0, wrDrop = 1'b0;
  logic [7:0] wrData = 8'd0;
  logic       wrReject;
  logic       rdEn = 1'b0;
  logic       rdCellAvail, rdSoc;
  logic [7:0] rdData;

  always #4 wrClk = ~wrClk;  // 125 MHz
  always #3 rdClk = ~rdClk;

  cellq_fifo dut_i (
    .rst(rst), .cellSize(cellSize), .wrClk(wrClk), .wrValid(wrValid), .wrSoc(wrSoc),
    .wrData(wrData), .wrCommit(wrCommit), .wrDrop(wrDrop), .wrReject(wrReject),
    .rdClk(rdClk), .rdEn(rdEn), .rdCellAvail(rdCellAvail), .rdSoc(rdSoc), .rdData(rdData)
  );

  int   nChk = 0, nFail = 0;
  int   cs = 16;
  int   rdPos = 0;
  int   expQ[$];
  int   lastCell[$];
  bit   wDone;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit socExpected(int pos);
    return (pos % cs) == 0;
  endfunction

  task automatic rdWait(int n);
    repeat (n) @(negedge rdClk);
  endtask

  task automatic doReset(int size);
    rst = 1'b1; cellSize = 8'(size); cs = size;
    wrValid = 0; wrSoc = 0; wrCommit = 0; wrDrop = 0; rdEn = 0;
    repeat (4) @(negedge wrClk);
    rst = 1'b0;
    expQ.delete(); rdPos = 0;
    @(negedge rdClk);
  endtask

  // endMode: 0 commit, 1 drop, 2 leave open
  task automatic sendCell(int n, int endMode, output bit rej);
    lastCell.delete(); rej = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge wrClk);
      if (i == 1) rej = wrReject;
      wrValid = 1; wrSoc = (i == 0); wrData = 8'($urandom);
      lastCell.push_back(int'(wrData));
    end
    @(negedge wrClk);
    if (n == 1) rej = wrReject;
    wrValid = 0; wrSoc = 0;
    wrCommit = (endMode == 0); wrDrop = (endMode == 1);
    @(negedge wrClk);
    wrCommit = 0; wrDrop = 0;
    if (endMode == 0 && !rej && n >= cs)
      for (int i = 0; i < cs; i++) expQ.push_back(lastCell[i]);
  endtask

  task automatic checkWord(string tag);
    int e;
    e = (expQ.size() > 0) ? expQ.pop_front() : -1;
    chk(int'(rdData) == e, {tag, " data"}, int'(rdData), e);
    chk(rdSoc == socExpected(rdPos), {tag, " R3 soc"}, int'(rdSoc), int'(socExpected(rdPos)));
    rdPos++;
  endtask

  task automatic readCells(int nCells, string tag);
    int words = nCells * cs;
    int idle = 0;
    @(negedge rdClk);
    while (words > 0) begin
      if (rdCellAvail) begin
        checkWord(tag); rdEn = 1; words--; idle = 0;
      end else begin
        rdEn = 0; idle++;
        if (idle > 3000) begin
          chk(0, {tag, " avail"}, 0, 1);
          words = 0;
        end
      end
      @(negedge rdClk);
    end
    rdEn = 0;
  endtask

  task automatic randomPhase(int nCells, string tag);
    wDone = 0;
    fork
      begin
        for (int k = 0; k < nCells; k++) begin
          int r; bit rej;
          repeat ($urandom_range(0, 3)) @(negedge wrClk);
          r = $urandom_range(0, 9);
          if (r <= 6)      sendCell(cs, 0, rej);
          else if (r == 7) sendCell($urandom_range(1, cs), 1, rej);
          else if (r == 8) sendCell($urandom_range(1, cs - 1), 0, rej);
          else             sendCell(cs + $urandom_range(1, 4), 0, rej);
          chk(!rej, {tag, " R8 no refusal with space"}, int'(rej), 0);
        end
        wDone = 1;
      end
      begin
        @(negedge rdClk);
        while (1) begin
          if (rdCellAvail) begin
            checkWord(tag); rdEn = 1;
          end else begin
            rdEn = 0;
            if (wDone && expQ.size() == 0) break;
          end
          @(negedge rdClk);
        end
        rdEn = 0;
      end
    join
    chk(expQ.size() == 0, {tag, " all delivered"}, expQ.size(), 0);
  endtask

  task automatic runSize(int size, string sizeTag, int nRand);
    bit rej;
    int held;
    int nFit;
    doReset(size);
    chk(!rdCellAvail, {sizeTag, " R1 avail"}, int'(rdCellAvail), 0);
    chk(!rdSoc, {sizeTag, " R1 soc"}, int'(rdSoc), 0);
    chk(!wrReject, {sizeTag, " R1 reject"}, int'(wrReject), 0);
    rdWait(20);
    chk(!rdCellAvail, {sizeTag, " R1 idle"}, int'(rdCellAvail), 0);

    // R9: reads with nothing available
    rdEn = 1; rdWait(6); rdEn = 0;

    // R10: full cell written, commit later
    sendCell(cs, 2, rej);
    rdWait(25);
    chk(!rdCellAvail, {sizeTag, " R10 uncommitted hidden"}, int'(rdCellAvail), 0);
    @(negedge wrClk); wrCommit = 1; @(negedge wrClk); wrCommit = 0;
    for (int i = 0; i < cs; i++) expQ.push_back(lastCell[i]);
    readCells(1, {sizeTag, " R9 R10 R2"});

    // R12: hold word
    sendCell(cs, 0, rej);
    rdWait(20);
    held = int'(rdData);
    rdWait(10);
    chk(int'(rdData) == held, {sizeTag, " R12 held"}, int'(rdData), held);
    chk(rdSoc == 1'b1, {sizeTag, " R12 soc held"}, int'(rdSoc), 1);
    readCells(1, {sizeTag, " R12"});

    // R4: drops
    sendCell(cs / 2, 1, rej);
    sendCell(cs, 1, rej);
    sendCell(cs, 0, rej);
    readCells(1, {sizeTag, " R4"});
    rdWait(25);
    chk(!rdCellAvail, {sizeTag, " R4 nothing extra"}, int'(rdCellAvail), 0);

    // R5: short commit
    sendCell(cs - 1, 0, rej);
    rdWait(25);
    chk(!rdCellAvail, {sizeTag, " R5 short hidden"}, int'(rdCellAvail), 0);
    sendCell(cs, 0, rej);
    readCells(1, {sizeTag, " R5"});

    // R6: overlong cell
    sendCell(cs + 3, 0, rej);
    sendCell(cs, 0, rej);
    readCells(2, {sizeTag, " R6"});

    // R7: new soc on open cell
    sendCell(cs / 2, 2, rej);
    sendCell(cs, 0, rej);
    readCells(1, {sizeTag, " R7"});
    rdWait(25);
    chk(!rdCellAvail, {sizeTag, " R7 nothing extra"}, int'(rdCellAvail), 0);

    // R8: fill to the admission limit
    nFit = 1536 / cs;
    for (int k = 0; k < nFit; k++) begin
      sendCell(cs, 0, rej);
      if (rej) chk(0, {sizeTag, " R8 fits"}, 1, 0);
    end
    nChk++;
    sendCell(cs, 0, rej);
    chk(rej, {sizeTag, " R8 refused"}, int'(rej), 1);
    @(negedge wrClk);
    chk(!wrReject, {sizeTag, " R8 pulse ends"}, int'(wrReject), 0);
    readCells(nFit, {sizeTag, " R8"});
    rdWait(25);
    chk(!rdCellAvail, {sizeTag, " R8 refused cell absent"}, int'(rdCellAvail), 0);
    sendCell(cs, 0, rej);
    chk(!rej, {sizeTag, " R8 space regained"}, int'(rej), 0);
    readCells(1, {sizeTag, " R8"});

    randomPhase(nRand, {sizeTag, " R2 random"});
  endtask

  initial begin
    void'($urandom(32'h5eed_c311));
    runSize(16, "cs16", 120);
    runSize(128, "R11 cs128", 25);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #1200000;
    nFail++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule